// File: doc/BRIEF.md
# Journaled Non-Volatile Byte Store Write Engine

This block makes a small RAM window look like byte-addressable non-volatile storage. Reads are served straight from the window RAM. Every accepted write updates the RAM copy at once. It then records the affected 16-bit halfwords as 32-bit records in a much larger backup array. That array is filled as a ring, one record slot after another. When the append pointer enters a new sector, the engine first reclaims the sector after it: it copies forward each record in that sector that is still the newest for its halfword, and then erases the sector. The backup array is modelled inside the block as a synchronous memory with fixed program and erase latencies.

The bus side is a single request port without back-pressure. A request (`req` high for one cycle) is never stalled. Exactly one response cycle (`rsp_valid`) follows it, and the response cannot be refused. `ready` is a plain status flag. It stays low while backup work is in progress. Any request made while it is low is rejected with an error response and has no effect. A read-only port exposes any backup slot, so the journal contents can be inspected.

Top module: `eemu_engine`

## Requirements
- R1: Out of reset, `ready` is high and `rsp_valid` is low. Every backup slot reads 0xFFFFFFFF, and every window byte reads 0xFF.
- R2: A backup record holds the halfword data in bits 31:16, a status code in bits 15:12 and the halfword index (byte address divided by two) in bits 11:0. The status codes are 0xF for erased, 0x7 for in-progress and 0x3 for valid. A record is first programmed with status in-progress, then changed to valid, so a finished record carries status 0x3.
- R3: A write is accepted only when `addr[1:0]` is 0 and `be` is one of 0001, 0010, 0100, 1000, 0011, 1100 or 1111. Any other byte-enable pattern, or a misaligned address, returns an error and has no effect. A one-byte write still produces one full record, and that record holds the merged halfword.
- R4: A write with `be`=1111 produces two records in consecutive slots: the low halfword first, then the high one.
- R5: Records go to consecutive slots. After the last slot the append pointer wraps to slot 0.
- R6: A request whose address is WIN_BYTES or greater returns an error and has no effect.
- R7: From the cycle after an accepted write until all of its records, including any reclaim work, are complete, `ready` is low. A request made while `ready` is low gets an error response and changes neither the window nor the backup array.
- R8: Each request produces `rsp_valid` in the following cycle. An error response carries read data 0. A successful read returns the window word.
- R9: When a record is due at the first slot of a sector, the engine first scans the following sector in slot order. It copies each valid record that is still the newest for its halfword to the append pointer, then erases that sector, and only then writes the new record.
- R10: A write whose record lands at a sector's first slot keeps `ready` low for longer than a write whose record lands in an already erased slot inside a sector.
- R11: `pk_data` shows, without a clock delay, the content of backup slot `pk_slot`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, one cycle per request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address of a 32-bit word lane |
| be | input | 4 | Byte enables for the write lanes |
| wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle for the previous request |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read data (0 on error) |
| ready | output | 1 | High when the engine can take a request |
| pk_slot | input | SLOT_W | Backup slot to inspect |
| pk_data | output | 32 | Content of that backup slot |

## Verification
The hardest situation to reach is a reclaim that finds live records in the victim sector and has to copy them forward. Right after the same reclaim, the ring wraps from the last slot back to slot 0. From the ports, getting there takes dozens of writes with the right mix of addresses. The stimulus leaves a few halfwords written only once near the start of the array. It then drives a long run of writes to a single halfword until the pointer comes back round to sector 0. The expected copy order and slot numbers follow from counting records, and the bench reads them through the slot inspection port.

// File: rtl/eemu_pkg.sv
package eemu_pkg;
  localparam logic [3:0] REC_ERASED = 4'hF;
  localparam logic [3:0] REC_PEND   = 4'h7;
  localparam logic [3:0] REC_VALID  = 4'h3;

  // Programming only clears bits: this mask turns an in-progress status into valid
  localparam logic [31:0] VALID_MASK = {16'hFFFF, REC_VALID, 12'hFFF};

  function automatic logic [31:0] rec_pack(input logic [15:0] d, input logic [3:0] st,
                                           input logic [11:0] idx);
    return {d, st, idx};
  endfunction
endpackage

// File: rtl/eemu_window.sv
module eemu_window #(
  parameter int WORDS = 4,
  localparam int WW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_word,
  input  logic [3:0]    wr_be,
  input  logic [31:0]   wr_data,
  input  logic [WW-1:0] rd_word,
  output logic [31:0]   rd_data
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (wr_en) begin
      for (int g = 0; g < 4; g++)
        if (wr_be[g]) mem[wr_word][8*g +: 8] <= wr_data[8*g +: 8];
    end
  end

  assign rd_data = mem[rd_word];
endmodule

// File: rtl/eemu_backup.sv
module eemu_backup #(
  parameter int SLOTS     = 64,
  parameter int SECT      = 16,
  parameter int PROG_CYC  = 3,
  parameter int ERASE_CYC = 20,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CW     = $clog2(ERASE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              erase,
  input  logic [SLOT_W-1:0] slot,
  input  logic [31:0]       data,
  output logic              done,
  input  logic [SLOT_W-1:0] sc_slot,
  output logic [31:0]       sc_data,
  input  logic [SLOT_W-1:0] pk_slot,
  output logic [31:0]       pk_data
);
  logic [31:0]       arr [SLOTS];
  logic              act, l_er;
  logic [CW-1:0]     cnt;
  logic [SLOT_W-1:0] l_slot;
  logic [31:0]       l_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) arr[i] <= '1;
      act <= 1'b0; l_er <= 1'b0; cnt <= '0; l_slot <= '0; l_data <= '1; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        act    <= 1'b1;
        l_er   <= erase;
        l_slot <= slot;
        l_data <= data;
        cnt    <= erase ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
      end else if (act) begin
        if (cnt == '0) begin
          act  <= 1'b0;
          done <= 1'b1;
          if (l_er) begin
            for (int i = 0; i < SECT; i++) arr[l_slot + SLOT_W'(i)] <= '1;
          end else begin
            arr[l_slot] <= arr[l_slot] & l_data;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign sc_data = arr[sc_slot];
  assign pk_data = arr[pk_slot];
endmodule

// File: rtl/eemu_ctrl.sv
module eemu_ctrl
  import eemu_pkg::*;
#(
  parameter int HW_N  = 8,
  parameter int SLOTS = 64,
  parameter int SECT  = 16,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int SCW    = $clog2(SECT),
  localparam int SEC_W  = SLOT_W - SCW,
  localparam int HW_W   = $clog2(HW_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        start_mask,
  input  logic [HW_W-2:0]   start_word,
  input  logic [15:0]       start_d0,
  input  logic [15:0]       start_d1,
  output logic              busy,
  output logic              fl_go,
  output logic              fl_erase,
  output logic [SLOT_W-1:0] fl_slot,
  output logic [31:0]       fl_data,
  input  logic              fl_done,
  output logic [SLOT_W-1:0] sc_slot,
  input  logic [31:0]       sc_data
);
  typedef enum logic [2:0] {C_IDLE, C_NEXT, C_SCAN, C_CPROG, C_CVAL, C_ERASE, C_WPROG, C_WVAL} cst_e;

  cst_e              st;
  logic [1:0]        pend;
  logic [15:0]       d0, d1;
  logic [HW_W-2:0]   wix;
  logic              cur;
  logic [SLOT_W-1:0] head;
  logic              recl_ok;
  logic [SCW-1:0]    scan;
  logic [HW_W-1:0]   cp_idx;
  logic [SLOT_W-1:0] loc_slot [HW_N];
  logic [HW_N-1:0]   loc_ok;

  logic [SEC_W-1:0]  victim;
  logic [HW_W-1:0]   sc_idx;
  logic              live;
  logic [SLOT_W-1:0] head_nx;
  logic [HW_W-1:0]   cur_idx;

  assign victim  = head[SLOT_W-1:SCW] + 1'b1;
  assign sc_slot = {victim, scan};
  assign sc_idx  = sc_data[HW_W-1:0];
  assign live    = (sc_data[15:12] == REC_VALID) && (sc_data[11:0] < 12'(HW_N)) &&
                   loc_ok[sc_idx] && (loc_slot[sc_idx] == sc_slot);
  assign head_nx = head + 1'b1;
  assign cur_idx = {wix, cur};
  assign busy    = (st != C_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= C_IDLE; pend <= '0; d0 <= '0; d1 <= '0; wix <= '0; cur <= 1'b0;
      head <= '0; recl_ok <= 1'b0; scan <= '0; cp_idx <= '0; loc_ok <= '0;
      for (int i = 0; i < HW_N; i++) loc_slot[i] <= '0;
      fl_go <= 1'b0; fl_erase <= 1'b0; fl_slot <= '0; fl_data <= '1;
    end else begin
      fl_go <= 1'b0;
      unique case (st)
        C_IDLE: if (start) begin
          pend <= start_mask; d0 <= start_d0; d1 <= start_d1; wix <= start_word;
          st   <= C_NEXT;
        end
        C_NEXT: begin
          if (pend == 2'b00) begin
            st <= C_IDLE;
          end else if (head[SCW-1:0] == '0 && !recl_ok) begin
            scan <= '0;
            st   <= C_SCAN;
          end else begin
            cur      <= ~pend[0];
            fl_go    <= 1'b1;
            fl_erase <= 1'b0;
            fl_slot  <= head;
            fl_data  <= rec_pack(pend[0] ? d0 : d1, REC_PEND,
                                 12'({wix, ~pend[0]}));
            st       <= C_WPROG;
          end
        end
        C_SCAN: begin
          if (live) begin
            cp_idx   <= sc_idx;
            fl_go    <= 1'b1;
            fl_erase <= 1'b0;
            fl_slot  <= head;
            fl_data  <= rec_pack(sc_data[31:16], REC_PEND, sc_data[11:0]);
            st       <= C_CPROG;
          end else if (&scan) begin
            fl_go    <= 1'b1;
            fl_erase <= 1'b1;
            fl_slot  <= {victim, {SCW{1'b0}}};
            st       <= C_ERASE;
          end else begin
            scan <= scan + 1'b1;
          end
        end
        C_CPROG, C_WPROG: if (fl_done) begin
          fl_go    <= 1'b1;
          fl_erase <= 1'b0;
          fl_data  <= VALID_MASK;
          st       <= (st == C_CPROG) ? C_CVAL : C_WVAL;
        end
        C_CVAL: if (fl_done) begin
          loc_slot[cp_idx] <= head;
          loc_ok[cp_idx]   <= 1'b1;
          head             <= head_nx;
          if (head_nx[SCW-1:0] == '0) recl_ok <= 1'b0;
          if (&scan) begin
            fl_go    <= 1'b1;
            fl_erase <= 1'b1;
            fl_slot  <= {victim, {SCW{1'b0}}};
            st       <= C_ERASE;
          end else begin
            scan <= scan + 1'b1;
            st   <= C_SCAN;
          end
        end
        C_ERASE: if (fl_done) begin
          recl_ok <= 1'b1;
          st      <= C_NEXT;
        end
        C_WVAL: if (fl_done) begin
          loc_slot[cur_idx] <= head;
          loc_ok[cur_idx]   <= 1'b1;
          head              <= head_nx;
          if (head_nx[SCW-1:0] == '0) recl_ok <= 1'b0;
          pend[cur]         <= 1'b0;
          st                <= C_NEXT;
        end
        default: st <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eemu_engine.sv
module eemu_engine #(
  parameter int WIN_BYTES = 16,
  parameter int ADDR_W    = 12,
  parameter int SLOTS     = 64,
  parameter int SECT      = 16,
  parameter int PROG_CYC  = 3,
  parameter int ERASE_CYC = 20,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              ready,
  input  logic [SLOT_W-1:0] pk_slot,
  output logic [31:0]       pk_data
);
  localparam int WORDS = WIN_BYTES / 4;
  localparam int WW    = $clog2(WORDS);
  localparam int HW_N  = WIN_BYTES / 2;

  logic [WW-1:0]     widx;
  logic [31:0]       ram_rd, merged;
  logic              in_range, be_ok, bad, wr_acc, busy;
  logic              fl_go, fl_erase, fl_done;
  logic [SLOT_W-1:0] fl_slot, sc_slot;
  logic [31:0]       fl_data, sc_data;

  assign widx     = addr[WW+1:2];
  assign in_range = (addr < ADDR_W'(WIN_BYTES)) && (addr[1:0] == 2'b00);
  always_comb begin
    unique case (be)
      4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111: be_ok = 1'b1;
      default: be_ok = 1'b0;
    endcase
  end
  assign ready  = !busy;
  assign bad    = busy || !in_range || (we && !be_ok);
  assign wr_acc = req && we && !bad;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign merged[8*g +: 8] = be[g] ? wdata[8*g +: 8] : ram_rd[8*g +: 8];
  end

  eemu_window #(.WORDS(WORDS)) u_win (
    .clk, .rst_n, .wr_en(wr_acc), .wr_word(widx), .wr_be(be), .wr_data(wdata),
    .rd_word(widx), .rd_data(ram_rd)
  );

  eemu_ctrl #(.HW_N(HW_N), .SLOTS(SLOTS), .SECT(SECT)) u_ctrl (
    .clk, .rst_n, .start(wr_acc),
    .start_mask({be[3] | be[2], be[1] | be[0]}), .start_word(widx),
    .start_d0(merged[15:0]), .start_d1(merged[31:16]), .busy,
    .fl_go, .fl_erase, .fl_slot, .fl_data, .fl_done, .sc_slot, .sc_data
  );

  eemu_backup #(.SLOTS(SLOTS), .SECT(SECT), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_bk (
    .clk, .rst_n, .go(fl_go), .erase(fl_erase), .slot(fl_slot), .data(fl_data),
    .done(fl_done), .sc_slot, .sc_data, .pk_slot, .pk_data
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= req;
      rsp_err   <= req && bad;
      rsp_rdata <= (req && !bad && !we) ? ram_rd : 32'h0;
    end
  end
endmodule

// File: rtl/eemu_checks.sv
module eemu_checks #(
  parameter int WIN_BYTES = 16,
  parameter int ADDR_W    = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [3:0]        be,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              ready
);
  AST_REQ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n) req |=> rsp_valid); // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !req |=> !rsp_valid); // R8
  AST_ERR_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> rsp_valid); // R8
  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (req && !ready) |=> rsp_err); // R7
  AST_OOB_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req && addr >= ADDR_W'(WIN_BYTES)) |=> rsp_err); // R6
  AST_WRITE_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && ready && addr < ADDR_W'(WIN_BYTES) && addr[1:0] == 2'b00 && be == 4'hF)
    |=> !ready); // R7
endmodule

bind eemu_engine eemu_checks #(.WIN_BYTES(WIN_BYTES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_eemu_engine.sv
`timescale 1ns/1ps
module sim_eemu_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic        rsp_valid, rsp_err, ready;
  logic [31:0] rsp_rdata, pk_data;
  logic [5:0]  pk_slot = '0;

  int checks = 0, errors = 0;
  logic        g_err, g_v;
  logic [31:0] g_data;
  int          lat;

  always #2 clk = ~clk;

  eemu_engine u0 (.clk, .rst_n, .req, .we, .addr, .be, .wdata, .rsp_valid, .rsp_err,
                  .rsp_rdata, .ready, .pk_slot, .pk_data);

  typedef struct packed {
    logic        w;
    logic [11:0] wa;
    logic [3:0]  wbe;
    logic [31:0] wd;
    logic        werr;
    logic [11:0] ra;
    logic        rerr;
    logic [31:0] rd;
  } vec_t;

  localparam vec_t TBL [7] = '{
    {1'b1, 12'h000, 4'b0001, 32'h000000A5, 1'b0, 12'h000, 1'b0, 32'hFFFFFFA5}, // R3 byte write
    {1'b1, 12'h004, 4'b1111, 32'h12345678, 1'b0, 12'h004, 1'b0, 32'h12345678}, // R4 full word
    {1'b1, 12'h000, 4'b1100, 32'hBEEF0000, 1'b0, 12'h000, 1'b0, 32'hBEEFFFA5}, // R3 upper half
    {1'b1, 12'h010, 4'b1111, 32'h11111111, 1'b1, 12'h010, 1'b1, 32'h00000000}, // R6 range
    {1'b1, 12'h008, 4'b0110, 32'h22222222, 1'b1, 12'h008, 1'b0, 32'hFFFFFFFF}, // R3 bad enables
    {1'b1, 12'h00A, 4'b0001, 32'h33333333, 1'b1, 12'h008, 1'b0, 32'hFFFFFFFF}, // R3 misaligned
    {1'b1, 12'h00C, 4'b0100, 32'h00330000, 1'b0, 12'h00C, 1'b0, 32'hFF33FFFF}  // R3 byte lane 2
  };

  function automatic logic [31:0] rec(input logic [15:0] d, input logic [11:0] idx);
    return {d, 4'h3, idx};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic do_req(input logic w, input logic [11:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0;
    g_err = rsp_err; g_v = rsp_valid; g_data = rsp_rdata;
  endtask

  task automatic wait_ready();
    lat = 0;
    while (!ready) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [3:0] b, input logic [31:0] d);
    do_req(1'b1, a, b, d);
    wait_ready();
  endtask

  task automatic peek(input string tag, input int s, input logic [31:0] exp);
    pk_slot = 6'(s);
    #1;
    chk(tag, pk_data, exp);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int lat_tbl [7];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'h0, ready}, 32'h1);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    peek("R1 slot0", 0, 32'hFFFFFFFF);
    peek("R1 slot63", 63, 32'hFFFFFFFF);
    do_req(1'b0, 12'h008, 4'h0, 32'h0);
    chk("R1 window", g_data, 32'hFFFFFFFF);
    chk("R8 valid", {31'h0, g_v}, 32'h1);

    foreach (TBL[i]) begin
      do_req(TBL[i].w, TBL[i].wa, TBL[i].wbe, TBL[i].wd);
      chk("R3/R6 write err", {31'h0, g_err}, {31'h0, TBL[i].werr});
      wait_ready();
      lat_tbl[i] = lat;
      do_req(1'b0, TBL[i].ra, 4'h0, 32'h0);
      chk("R6/R8 read err", {31'h0, g_err}, {31'h0, TBL[i].rerr});
      chk("R3/R8 read data", g_data, TBL[i].rd);
    end

    // R2 R3 R4 record contents
    peek("R2 slot0", 0, rec(16'hFFA5, 12'h000));
    peek("R4 slot1", 1, rec(16'h5678, 12'h002));
    peek("R4 slot2", 2, rec(16'h1234, 12'h003));
    peek("R3 slot3", 3, rec(16'hBEEF, 12'h001));
    peek("R3 slot4", 4, rec(16'hFF33, 12'h007));
    peek("R5 slot5 empty", 5, 32'hFFFFFFFF);
    // R10 sector-start write is slower than a mid-sector one
    chk("R10 latency", {31'h0, lat_tbl[0] > lat_tbl[2]}, 32'h1);

    // R7 busy rejection
    do_req(1'b1, 12'h00C, 4'b0011, 32'h00007777);
    chk("R7 ready low", {31'h0, ready}, 32'h0);
    do_req(1'b1, 12'h008, 4'b1111, 32'hDEADDEAD);
    chk("R7 busy write err", {31'h0, g_err}, 32'h1);
    do_req(1'b0, 12'h00C, 4'h0, 32'h0);
    chk("R7 busy read err", {31'h0, g_err}, 32'h1);
    chk("R8 err data zero", g_data, 32'h0);
    wait_ready();
    do_req(1'b0, 12'h008, 4'h0, 32'h0);
    chk("R7 no effect window", g_data, 32'hFFFFFFFF);
    peek("R7 slot5", 5, rec(16'h7777, 12'h006));
    peek("R7 no extra record", 6, 32'hFFFFFFFF);

    // R9 reclaim: fill slots 6..47 with halfword 0
    for (int k = 6; k < 48; k++) wr(12'h000, 4'b0011, 32'(k));
    peek("R9 slot47", 47, rec(16'd47, 12'h000));
    wr(12'h000, 4'b0011, 32'h0000C0DE);
    peek("R9 copy48", 48, rec(16'h5678, 12'h002));
    peek("R9 copy49", 49, rec(16'h1234, 12'h003));
    peek("R9 copy50", 50, rec(16'hBEEF, 12'h001));
    peek("R9 copy51", 51, rec(16'hFF33, 12'h007));
    peek("R9 copy52", 52, rec(16'h7777, 12'h006));
    peek("R9 user53", 53, rec(16'hC0DE, 12'h000));
    peek("R9 erased1", 1, 32'hFFFFFFFF);
    do_req(1'b0, 12'h000, 4'h0, 32'h0);
    chk("R9 read0", g_data, 32'hBEEFC0DE);
    do_req(1'b0, 12'h00C, 4'h0, 32'h0);
    chk("R9 read12", g_data, 32'hFF337777);

    // R5 wrap
    for (int k = 54; k < 64; k++) wr(12'h000, 4'b0011, 32'(k));
    wr(12'h000, 4'b0011, 32'h0000D00D);
    peek("R5 wrap slot0", 0, rec(16'hD00D, 12'h000));
    peek("R5 slot1 empty", 1, 32'hFFFFFFFF);
    peek("R9 sector1 erased", 16, 32'hFFFFFFFF);
    peek("R9 sector3 kept", 48, rec(16'h5678, 12'h002));
    peek("R11 slot63", 63, rec(16'd63, 12'h000));
    do_req(1'b0, 12'h000, 4'h0, 32'h0);
    chk("R5 read0", g_data, 32'hBEEFD00D);

    finish_run();
  end
endmodule